// File: doc/BRIEF.md
# Data Cache Maintenance Engine

This block carries out maintenance commands on a first-level data cache. It holds the cache's tag, coherence-state and line-data storage itself. Each command names an operation, a cache-level bit, the virtual address bits that pick a set and a way, and the physical tag to compare against. Depending on the operation, the engine invalidates the line, writes a dirty line back, or installs a new tag without fetching any data. Writebacks leave through a plain memory write port as a burst of doubleword beats, one beat per acknowledge.

Commands are taken one at a time. The engine stays busy from the cycle it accepts a command until the command has finished, including the final acknowledged writeback beat. Completion is marked by a one-cycle `done` pulse. A store port loads doublewords into the line storage and marks resident lines as written. A combinational read port shows any line's tag, state, written flag and data.

The controller steps through four states:
- `S_IDLE`: waits for a command.
- `S_EXAM`: compares tags and decides whether a writeback is needed.
- `S_WRBACK`: issues the beats.
- `S_FINISH`: commits the tag and state update and raises `done`.

Its transitions are:
- accept: from `S_IDLE` to `S_EXAM`, or straight to `S_FINISH` when the level bit is set.
- need-writeback: from `S_EXAM` to `S_WRBACK`.
- no-writeback: from `S_EXAM` to `S_FINISH`.
- last-beat-acked: from `S_WRBACK` to `S_FINISH`.
- retire: from `S_FINISH` to `S_IDLE`.

With the default parameters:
- the set is `cmd_vsel[3:0]` and the way is `cmd_vsel[4]`;
- the line is 32 bytes, made of four 64-bit beats;
- the stored tag is 23 bits, the physical address bits above the set field.

Top module: `cmo_engine`

## Requirements
- R1: After reset every line reads as not valid, with state 0 (invalid) and written flag 0. `busy` is 0, `cmd_ready` is 1 and `mem_wr_valid` is 0.
- R2: `cmd_ready` is 1 only when idle. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. From that edge `busy` is 1 and `cmd_ready` is 0 until completion, including while writeback beats are pending. `done` is high for exactly one cycle, and `busy` is already 0 in that cycle.
- R3: A command with `cmd_level`=1 changes no line and issues no write, for any operation code. Its `done` pulse comes in the second cycle after acceptance.
- R4: Op code 0 (index writeback-invalidate) writes the selected line back if its written flag is set. In every case the line is then left invalid with its written flag cleared.
- R5: Op codes 1, 2 and 7 complete without any write and without changing the line.
- R6: Op code 3 (make-dirty) writes the resident line back first, but only if it is written and its stored tag differs from `cmd_ptag`. It then stores `cmd_ptag`, sets state 3 (dirty-exclusive) and keeps the written flag unchanged. No data is fetched.
- R7: Op code 4 (hit invalidate) invalidates the line when it is valid and its tag equals `cmd_ptag`, and never writes back. On a miss the line is unchanged.
- R8: Op code 5 (hit writeback-invalidate) writes back only on a tag hit with the written flag set. It always leaves the line invalid.
- R9: Op code 6 (hit writeback) writes back on a tag hit with the written flag set, then clears the flag. The line stays valid with its tag and state. Otherwise the line is unchanged.
- R10: A writeback is four beats. Beat j carries address {stored tag, set, j, 3'b000} and the line's doubleword j. Each beat holds its address and data until `mem_wr_ack` is sampled high.
- R11: A store writes `st_data` into the addressed doubleword. It sets the written flag only if the line is valid. A store presented while `busy` is 1 is ignored.
- R12: The read port shows the addressed line's validity, tag, state (0 invalid, 1 shared, 2 clean-exclusive, 3 dirty-exclusive), written flag and doubleword `rd_beat`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Operation code 0..7 |
| cmd_level | input | 1 | 1 = targets a secondary cache (no-op) |
| cmd_vsel | input | SET_W+WAY_W | Virtual address bits above line offset: set (low), way (high) |
| cmd_ptag | input | TAG_W | Physical tag for comparison or install |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_wr_valid | output | 1 | Writeback beat pending |
| mem_wr_ack | input | 1 | Memory accepts the pending beat |
| mem_wr_addr | output | ADDR_W | Byte address of the beat |
| mem_wr_data | output | 64 | Beat data |
| st_en | input | 1 | Store strobe |
| st_set | input | SET_W | Store set |
| st_way | input | WAY_W | Store way |
| st_beat | input | BEAT_W | Store doubleword within line |
| st_data | input | 64 | Store data |
| rd_set | input | SET_W | Read set |
| rd_way | input | WAY_W | Read way |
| rd_beat | input | BEAT_W | Read doubleword |
| rd_valid | output | 1 | Line holds a real tag |
| rd_tag | output | TAG_W | Stored tag |
| rd_state | output | 2 | Coherence state |
| rd_written | output | 1 | Written flag |
| rd_data | output | 64 | Doubleword read |

## Verification
The embedded properties assume the memory side may hold `mem_wr_ack` low for any number of cycles. They also assume `mem_wr_ack` means nothing while no beat is pending. They assume commands and stores come as single-cycle strobes sampled only at clock edges. The stimulus raises a command only after seeing `cmd_ready` high, then drops it the next cycle. It sends stores only while the engine is idle, apart from one deliberate store aimed at a busy engine. It switches between always-ready and throttled acknowledge patterns so the beat-hold and address-step properties are exercised under stalls.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    localparam int DW = 64;

    typedef enum logic [2:0] {
        OP_IDX_WB_INV  = 3'd0,
        OP_IDX_LD_TAG  = 3'd1,
        OP_IDX_ST_TAG  = 3'd2,
        OP_MAKE_DIRTY  = 3'd3,
        OP_HIT_INV     = 3'd4,
        OP_HIT_WB_INV  = 3'd5,
        OP_HIT_WB      = 3'd6,
        OP_HIT_SET_VIR = 3'd7
    } cmo_op_e;

    typedef enum logic [1:0] {
        LS_INVALID = 2'd0,
        LS_SHARED  = 2'd1,
        LS_CLEAN   = 2'd2,
        LS_DIRTY   = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXAM,
        S_WRBACK,
        S_FINISH
    } eng_state_e;

endpackage

// File: rtl/cmo_tag_array.sv
module cmo_tag_array
    import cmo_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int TAG_W = 23,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [WAY_W-1:0] lk_way,
    output logic [TAG_W:0]   lk_tag,
    output line_state_e      lk_state,
    output logic             lk_w,
    input  logic [SET_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic [TAG_W:0]   rd_tag,
    output line_state_e      rd_state,
    output logic             rd_w,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [TAG_W:0]   upd_tag,
    input  line_state_e      upd_state,
    input  logic             upd_w,
    input  logic             mark_en,
    input  logic [SET_W-1:0] mark_set,
    input  logic [WAY_W-1:0] mark_way
);
    // MSB set = reserved tag that no command tag can equal
    localparam logic [TAG_W:0] BAD_TAG = {1'b1, {TAG_W{1'b0}}};

    logic [TAG_W:0] tag_a [SETS][WAYS];
    line_state_e    st_a  [SETS][WAYS];
    logic           w_a   [SETS][WAYS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            localparam logic [SET_W-1:0] S_ID = SET_W'(s);
            localparam logic [WAY_W-1:0] W_ID = WAY_W'(w);
            logic [TAG_W:0] tag_r;
            line_state_e    st_r;
            logic           w_r;
            logic           upd_hit;
            logic           mark_hit;

            assign upd_hit  = upd_en && (upd_set == S_ID) && (upd_way == W_ID);
            assign mark_hit = mark_en && (mark_set == S_ID) && (mark_way == W_ID);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_r <= BAD_TAG;
                    st_r  <= LS_INVALID;
                    w_r   <= 1'b0;
                end else if (upd_hit) begin
                    tag_r <= upd_tag;
                    st_r  <= upd_state;
                    w_r   <= upd_w;
                end else if (mark_hit && !tag_r[TAG_W]) begin
                    w_r <= 1'b1;
                end
            end

            assign tag_a[s][w] = tag_r;
            assign st_a[s][w]  = st_r;
            assign w_a[s][w]   = w_r;
        end
    end

    assign lk_tag   = tag_a[lk_set][lk_way];
    assign lk_state = st_a[lk_set][lk_way];
    assign lk_w     = w_a[lk_set][lk_way];
    assign rd_tag   = tag_a[rd_set][rd_way];
    assign rd_state = st_a[rd_set][rd_way];
    assign rd_w     = w_a[rd_set][rd_way];

endmodule

// File: rtl/cmo_data_array.sv
module cmo_data_array
    import cmo_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int BEATS = 4,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [DW-1:0]     wr_data,
    input  logic [SET_W-1:0]  a_set,
    input  logic [WAY_W-1:0]  a_way,
    input  logic [BEAT_W-1:0] a_beat,
    output logic [DW-1:0]     a_data,
    input  logic [SET_W-1:0]  b_set,
    input  logic [WAY_W-1:0]  b_way,
    input  logic [BEAT_W-1:0] b_beat,
    output logic [DW-1:0]     b_data
);
    logic [DW-1:0] mem [SETS][WAYS][BEATS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_set][wr_way][wr_beat] <= wr_data;
        end
    end

    assign a_data = mem[a_set][a_way][a_beat];
    assign b_data = mem[b_set][b_way][b_beat];

endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
    import cmo_pkg::*;
#(
    parameter int SET_W  = 4,
    parameter int WAY_W  = 1,
    parameter int TAG_W  = 23,
    parameter int BEAT_W = 2,
    localparam int ADDR_W = TAG_W + SET_W + BEAT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_level,
    input  logic [SET_W-1:0]  cmd_set,
    input  logic [WAY_W-1:0]  cmd_way,
    input  logic [TAG_W-1:0]  cmd_tag,
    output logic              busy,
    output logic              done,
    output logic [SET_W-1:0]  lk_set,
    output logic [WAY_W-1:0]  lk_way,
    output logic [BEAT_W-1:0] lk_beat,
    input  logic [TAG_W:0]    lk_tag,
    input  line_state_e       lk_state,
    input  logic              lk_w,
    output logic              upd_en,
    output logic [TAG_W:0]    upd_tag,
    output line_state_e       upd_state,
    output logic              upd_w,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack
);
    localparam logic [TAG_W:0]    BAD_TAG   = {1'b1, {TAG_W{1'b0}}};
    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    eng_state_e        state_q, state_d;
    cmo_op_e           op_q;
    logic              lvl_q;
    logic [SET_W-1:0]  set_q;
    logic [WAY_W-1:0]  way_q;
    logic [TAG_W-1:0]  ptag_q;
    logic [BEAT_W-1:0] beat_q;
    logic              done_q;
    logic              hit;
    logic              wb_need;

    assign hit = (lk_tag == {1'b0, ptag_q});

    always_comb begin
        unique case (op_q)
            OP_IDX_WB_INV:  wb_need = lk_w;
            OP_MAKE_DIRTY:  wb_need = lk_w && !hit;
            OP_HIT_WB_INV:  wb_need = lk_w && hit;
            OP_HIT_WB:      wb_need = lk_w && hit;
            OP_IDX_LD_TAG,
            OP_IDX_ST_TAG,
            OP_HIT_INV,
            OP_HIT_SET_VIR: wb_need = 1'b0;
            default:        wb_need = 1'b0;
        endcase
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (cmd_valid) state_d = cmd_level ? S_FINISH : S_EXAM;
            S_EXAM:   state_d = wb_need ? S_WRBACK : S_FINISH;
            S_WRBACK: if (wb_ack && beat_q == LAST_BEAT) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // command latch, beat counter, done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_IDX_WB_INV;
            lvl_q  <= 1'b0;
            set_q  <= '0;
            way_q  <= '0;
            ptag_q <= '0;
            beat_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == S_FINISH);
            if (state_q == S_IDLE && cmd_valid) begin
                op_q   <= cmo_op_e'(cmd_op);
                lvl_q  <= cmd_level;
                set_q  <= cmd_set;
                way_q  <= cmd_way;
                ptag_q <= cmd_tag;
            end
            if (state_q == S_EXAM) beat_q <= '0;
            else if (state_q == S_WRBACK && wb_ack) beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        cmd_ready = (state_q == S_IDLE);
        done      = done_q;
        wb_valid  = (state_q == S_WRBACK);
        wb_addr   = {lk_tag[TAG_W-1:0], set_q, beat_q, 3'b000};
        lk_set    = set_q;
        lk_way    = way_q;
        lk_beat   = beat_q;
        upd_en    = 1'b0;
        upd_tag   = lk_tag;
        upd_state = lk_state;
        upd_w     = lk_w;
        if (state_q == S_FINISH && !lvl_q) begin
            unique case (op_q)
                OP_IDX_WB_INV, OP_HIT_WB_INV: begin
                    upd_en    = 1'b1;
                    upd_tag   = BAD_TAG;
                    upd_state = LS_INVALID;
                    upd_w     = 1'b0;
                end
                OP_MAKE_DIRTY: begin
                    upd_en    = 1'b1;
                    upd_tag   = {1'b0, ptag_q};
                    upd_state = LS_DIRTY;
                end
                OP_HIT_INV: begin
                    upd_en    = hit;
                    upd_tag   = BAD_TAG;
                    upd_state = LS_INVALID;
                    upd_w     = 1'b0;
                end
                OP_HIT_WB: begin
                    upd_en = hit && lk_w;
                    upd_w  = 1'b0;
                end
                OP_IDX_LD_TAG, OP_IDX_ST_TAG, OP_HIT_SET_VIR: upd_en = 1'b0;
                default: upd_en = 1'b0;
            endcase
        end
    end

    // R10: a pending beat holds until acknowledged
    a_r10_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_addr)));

    // R10: consecutive beats step by one doubleword
    a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ack) |=> (!wb_valid || wb_addr == $past(wb_addr) + ADDR_W'(8)));

    // R2: done lasts one cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: engine is idle when done is shown
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cmd_ready));

    // R3: a secondary-level command never starts a writeback
    a_r3_level_nowb: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_level) |=> (!wb_valid && busy));

endmodule

// File: rtl/cmo_engine.sv
module cmo_engine
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 16,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int BEATS  = LINE_BYTES / 8,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_level,
    input  logic [SET_W+WAY_W-1:0] cmd_vsel,
    input  logic [TAG_W-1:0]  cmd_ptag,
    output logic              busy,
    output logic              done,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ack,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [63:0]       mem_wr_data,
    input  logic              st_en,
    input  logic [SET_W-1:0]  st_set,
    input  logic [WAY_W-1:0]  st_way,
    input  logic [BEAT_W-1:0] st_beat,
    input  logic [63:0]       st_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [1:0]        rd_state,
    output logic              rd_written,
    output logic [63:0]       rd_data
);
    logic [SET_W-1:0]  lk_set;
    logic [WAY_W-1:0]  lk_way;
    logic [BEAT_W-1:0] lk_beat;
    logic [TAG_W:0]    lk_tag;
    line_state_e       lk_state;
    logic              lk_w;
    logic              upd_en;
    logic [TAG_W:0]    upd_tag;
    line_state_e       upd_state;
    logic              upd_w;
    logic [TAG_W:0]    rd_tag_raw;
    line_state_e       rd_state_e;
    logic              st_live;

    assign st_live = st_en && !busy;

    cmo_ctrl #(
        .SET_W (SET_W),
        .WAY_W (WAY_W),
        .TAG_W (TAG_W),
        .BEAT_W(BEAT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_op   (cmd_op),
        .cmd_level(cmd_level),
        .cmd_set  (cmd_vsel[SET_W-1:0]),
        .cmd_way  (cmd_vsel[SET_W+WAY_W-1:SET_W]),
        .cmd_tag  (cmd_ptag),
        .busy     (busy),
        .done     (done),
        .lk_set   (lk_set),
        .lk_way   (lk_way),
        .lk_beat  (lk_beat),
        .lk_tag   (lk_tag),
        .lk_state (lk_state),
        .lk_w     (lk_w),
        .upd_en   (upd_en),
        .upd_tag  (upd_tag),
        .upd_state(upd_state),
        .upd_w    (upd_w),
        .wb_valid (mem_wr_valid),
        .wb_addr  (mem_wr_addr),
        .wb_ack   (mem_wr_ack)
    );

    cmo_tag_array #(
        .SETS (SETS),
        .WAYS (WAYS),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (lk_set),
        .lk_way   (lk_way),
        .lk_tag   (lk_tag),
        .lk_state (lk_state),
        .lk_w     (lk_w),
        .rd_set   (rd_set),
        .rd_way   (rd_way),
        .rd_tag   (rd_tag_raw),
        .rd_state (rd_state_e),
        .rd_w     (rd_written),
        .upd_en   (upd_en),
        .upd_set  (lk_set),
        .upd_way  (lk_way),
        .upd_tag  (upd_tag),
        .upd_state(upd_state),
        .upd_w    (upd_w),
        .mark_en  (st_live),
        .mark_set (st_set),
        .mark_way (st_way)
    );

    cmo_data_array #(
        .SETS (SETS),
        .WAYS (WAYS),
        .BEATS(BEATS)
    ) u_data (
        .clk    (clk),
        .wr_en  (st_live),
        .wr_set (st_set),
        .wr_way (st_way),
        .wr_beat(st_beat),
        .wr_data(st_data),
        .a_set  (lk_set),
        .a_way  (lk_way),
        .a_beat (lk_beat),
        .a_data (mem_wr_data),
        .b_set  (rd_set),
        .b_way  (rd_way),
        .b_beat (rd_beat),
        .b_data (rd_data)
    );

    assign rd_valid = !rd_tag_raw[TAG_W];
    assign rd_tag   = rd_tag_raw[TAG_W-1:0];
    assign rd_state = rd_state_e;

endmodule

// File: tb/test_cmo_engine.sv
module test_cmo_engine;

    localparam int SET_W = 4;
    localparam int TAG_W = 23;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [2:0]  cmd_op;
    logic        cmd_level;
    logic [4:0]  cmd_vsel;
    logic [22:0] cmd_ptag;
    logic        busy;
    logic        done;
    logic        mem_wr_valid;
    logic        mem_wr_ack = 1'b0;
    logic [31:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        st_en;
    logic [3:0]  st_set;
    logic [0:0]  st_way;
    logic [1:0]  st_beat;
    logic [63:0] st_data;
    logic [3:0]  rd_set;
    logic [0:0]  rd_way;
    logic [1:0]  rd_beat;
    logic        rd_valid;
    logic [22:0] rd_tag;
    logic [1:0]  rd_state;
    logic        rd_written;
    logic [63:0] rd_data;

    always #10 clk = ~clk;

    cmo_engine i_cmo_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_level(cmd_level), .cmd_vsel(cmd_vsel), .cmd_ptag(cmd_ptag),
        .busy(busy), .done(done),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ack(mem_wr_ack),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .st_en(st_en), .st_set(st_set), .st_way(st_way), .st_beat(st_beat),
        .st_data(st_data),
        .rd_set(rd_set), .rd_way(rd_way), .rd_beat(rd_beat),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_state(rd_state),
        .rd_written(rd_written), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model of the line storage
    bit          m_valid [16][2];
    logic [22:0] m_tag   [16][2];
    logic [1:0]  m_st    [16][2];
    bit          m_w     [16][2];
    logic [63:0] m_data  [16][2][4];

    logic [95:0] sb_q[$];
    bit   slow_ack  = 1'b0;
    int   ack_cnt   = 0;
    bit   busy_bad  = 1'b0;
    int   poke_s    = -1;
    int   poke_w    = 0;
    int   poke_b    = 0;
    logic [63:0] poke_d = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] got, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // monitor: drives acknowledge, pops scoreboard on each handshake
    always @(negedge clk) begin
        logic [95:0] e;
        ack_cnt = ack_cnt + 1;
        mem_wr_ack = slow_ack ? (ack_cnt % 3 == 0) : 1'b1;
        if (rst_n && mem_wr_valid) begin
            if (!busy || cmd_ready) busy_bad = 1'b1;
            if (mem_wr_ack) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected beat", {mem_wr_addr, mem_wr_data}, '0);
                end else begin
                    e = sb_q.pop_front();
                    chk({mem_wr_addr, mem_wr_data} == e, "R10", "beat",
                        {mem_wr_addr, mem_wr_data}, e);
                end
            end
        end
    end

    task automatic chk_line(input int s, input int w, input string req);
        logic [27:0] got, exp;
        rd_set = 4'(s); rd_way = 1'(w); rd_beat = 2'd0;
        #1;
        got = {rd_valid, rd_state, rd_written, m_valid[s][w] ? rd_tag : 23'd0};
        exp = {m_valid[s][w], m_st[s][w], m_w[s][w], m_valid[s][w] ? m_tag[s][w] : 23'd0};
        chk(got == exp, req, "line state", 96'(got), 96'(exp));
    endtask

    task automatic chk_data(input int s, input int w, input int b, input string req);
        rd_set = 4'(s); rd_way = 1'(w); rd_beat = 2'(b);
        #1;
        chk(rd_data == m_data[s][w][b], req, "line data", 96'(rd_data), 96'(m_data[s][w][b]));
    endtask

    task automatic do_store(input int s, input int w, input int b, input logic [63:0] d);
        @(negedge clk);
        st_en = 1'b1; st_set = 4'(s); st_way = 1'(w); st_beat = 2'(b); st_data = d;
        @(negedge clk);
        st_en = 1'b0;
        m_data[s][w][b] = d;
        if (m_valid[s][w]) m_w[s][w] = 1'b1;
    endtask

    task automatic fill(input int s, input int w, input logic [31:0] seed);
        for (int j = 0; j < 4; j++) do_store(s, w, j, {seed, 32'(j) ^ 32'h5a5a0000});
    endtask

    // driver: computes expectation from the requirements, pushes beats, runs command
    task automatic do_op(input int op, input bit lvl, input int s, input int w,
                         input logic [22:0] pt, input string req);
        bit hit, wb, got_done;
        hit = m_valid[s][w] && (m_tag[s][w] == pt);
        wb  = 1'b0;
        if (!lvl) begin
            case (op)
                0:       wb = m_w[s][w];
                3:       wb = m_w[s][w] && !hit;
                5, 6:    wb = m_w[s][w] && hit;
                default: wb = 1'b0;
            endcase
        end
        if (wb) begin
            for (int j = 0; j < 4; j++)
                sb_q.push_back({m_tag[s][w], 4'(s), 2'(j), 3'b000, m_data[s][w][j]});
        end
        if (!lvl) begin
            case (op)
                0, 5: begin m_valid[s][w] = 0; m_st[s][w] = 2'd0; m_w[s][w] = 0; end
                3:    begin m_valid[s][w] = 1; m_tag[s][w] = pt; m_st[s][w] = 2'd3; end
                4:    if (hit) begin m_valid[s][w] = 0; m_st[s][w] = 2'd0; m_w[s][w] = 0; end
                6:    if (hit && m_w[s][w]) m_w[s][w] = 0;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R2", "ready when idle", 96'(cmd_ready), 96'(1));
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_level = lvl;
        cmd_vsel = {1'(w), 4'(s)}; cmd_ptag = pt;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy && !cmd_ready, "R2", "busy after accept", 96'({busy, cmd_ready}), 96'(2'b10));
        busy_bad = 1'b0;
        got_done = 1'b0;
        for (int k = 0; k < 300 && !got_done; k++) begin
            if (done) begin
                got_done = 1'b1;
            end else if (poke_s >= 0 && busy) begin
                st_en = 1'b1; st_set = 4'(poke_s); st_way = 1'(poke_w);
                st_beat = 2'(poke_b); st_data = poke_d;
                @(negedge clk);
                st_en = 1'b0;
                poke_s = -1;
            end else begin
                @(negedge clk);
            end
        end
        chk(got_done && !busy, "R2", "done with idle", 96'({got_done, busy}), 96'(2'b10));
        @(negedge clk);
        chk(!done, "R2", "done one cycle", 96'(done), 96'(0));
        chk(sb_q.size() == 0, "R10", "beats outstanding", 96'(sb_q.size()), 96'(0));
        chk(!busy_bad, "R2", "busy while beat pending", 96'(busy_bad), 96'(0));
        chk_line(s, w, req);
    endtask

    initial begin
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 2; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = '0; m_st[s][w] = 2'd0; m_w[s][w] = 0;
                for (int b = 0; b < 4; b++) m_data[s][w][b] = '0;
            end
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_level = 1'b0;
        cmd_vsel = '0; cmd_ptag = '0; st_en = 1'b0; st_set = '0; st_way = '0;
        st_beat = '0; st_data = '0; rd_set = '0; rd_way = '0; rd_beat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!busy && cmd_ready && !mem_wr_valid, "R1", "idle after reset",
            96'({busy, cmd_ready, mem_wr_valid}), 96'(3'b010));
        chk_line(0, 0, "R1");
        chk_line(15, 1, "R1");

        // R6: install tag on empty line, no data fetch
        do_op(3, 0, 3, 0, 23'h001234, "R6");
        // R11/R12: stores mark a valid line written, readable
        fill(3, 0, 32'hcafe0003);
        chk_line(3, 0, "R11");
        chk_data(3, 0, 2, "R12");
        do_store(3, 1, 2, 64'h1111_2222_3333_4444);
        chk_line(3, 1, "R11");
        do_store(5, 1, 0, 64'h0bad_f00d_0000_0005);
        chk_data(5, 1, 0, "R12");

        // R9: hit writeback, miss then hit with throttled acks and a store while busy
        do_op(6, 0, 3, 0, 23'h00abc5, "R9");
        slow_ack = 1'b1;
        poke_s = 3; poke_w = 1; poke_b = 2; poke_d = 64'hdead_dead_dead_dead;
        do_op(6, 0, 3, 0, 23'h001234, "R9");
        slow_ack = 1'b0;
        chk_data(3, 1, 2, "R11");
        chk_line(3, 1, "R11");
        do_op(6, 0, 3, 0, 23'h001234, "R9");

        // R8: clean hit invalidates without writeback; dirty hit writes back
        do_op(5, 0, 3, 0, 23'h001234, "R8");
        do_op(3, 0, 7, 1, 23'h001234, "R8");
        fill(7, 1, 32'h70017001);
        do_op(5, 0, 7, 1, 23'h001234, "R8");

        // R6: tag change on written line writes old line, keeps written flag
        do_op(3, 0, 9, 0, 23'h001234, "R6");
        fill(9, 0, 32'h90009000);
        slow_ack = 1'b1;
        do_op(3, 0, 9, 0, 23'h00abc5, "R6");
        slow_ack = 1'b0;
        do_op(3, 0, 9, 0, 23'h00abc5, "R6");

        // R4: index writeback-invalidate, dirty then already invalid
        do_op(0, 0, 9, 0, 23'h000000, "R4");
        do_op(0, 0, 9, 0, 23'h000000, "R4");
        do_op(3, 0, 10, 1, 23'h000777, "R4");
        do_op(0, 0, 10, 1, 23'h000000, "R4");

        // R7: hit invalidate, miss untouched then hit, never writes back
        do_op(3, 0, 2, 1, 23'h001234, "R7");
        fill(2, 1, 32'h20012001);
        do_op(4, 0, 2, 1, 23'h00abc5, "R7");
        do_op(4, 0, 2, 1, 23'h001234, "R7");

        // R5 and R3: no-op codes and secondary-level commands
        do_op(3, 0, 4, 0, 23'h004444, "R5");
        fill(4, 0, 32'h40004000);
        do_op(1, 0, 4, 0, 23'h004444, "R5");
        do_op(2, 0, 4, 0, 23'h000001, "R5");
        do_op(7, 0, 4, 0, 23'h004444, "R5");
        do_op(0, 1, 4, 0, 23'h004444, "R3");
        do_op(5, 1, 4, 0, 23'h004444, "R3");
        do_op(3, 1, 4, 0, 23'h000999, "R3");
        chk_data(4, 0, 3, "R3");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule